// File: doc/BRIEF.md
# Split-Phase Mersenne Twister Random Word Generator

This block produces a stream of 32-bit uniform pseudo-random words using the 624-word, 32-bit Mersenne Twister recurrence with its usual constants. A 32-bit seed is written in with a one-cycle load strobe. The block then fills its state memory with the standard seeding recurrence, one word per clock. After that it refreshes the whole state in a separate twist pass, three clocks per word.

After the pass it streams the refreshed state through a tempering stage, one word per clock, over a ready/valid handshake. When all 624 words have been sent, output stops and the state is twisted again. The twist never overlaps the output stream, so the tempering path stays a short, pipelined read-temper-register chain. The state lives in a single memory with one read port and one write port, so block RAM can be inferred.

Typical use is as a noise or random-time source for a downstream consumer. The consumer accepts words when it wants them and tolerates the periodic pause of about 1874 cycles.

Top module: `mt_split_gen`

## Requirements
- R1: After reset, out_valid is 0 and stays 0 until the first seed_load.
- R2: Seeding sets state word 0 to seed_in and word k (1..623) to 1812433253*(w[k-1] ^ (w[k-1]>>30)) + k, modulo 2^32; for seed 5489 the first outputs are 3499211612, 581869302, 3890346734, 3586334585, 545404204, 4161255391, 3922919429, 949333985, 2715962298, 1323567403.
- R3: Each twist rewrites word i in ascending order from y = {bit 31 of w[i], bits 30:0 of w[(i+1) mod 624]} as w[(i+397) mod 624] ^ (y>>1) ^ (y[0] ? 0x9908B0DF : 0). Words already rewritten in this pass are used with their new values. Batches after the first continue the reference sequence.
- R4: Each output is the state word tempered by t^=t>>11; t^=(t<<7)&0x9D2C5680; t^=(t<<15)&0xEFC60000; t^=t>>18, with words taken in index order 0..623.
- R5: out_valid first rises at the 2497th rising clock edge after the edge that samples seed_load (623 seeding cycles, 1872 twist cycles, 2 pipeline cycles).
- R6: With out_ready held at 1, out_valid stays high for exactly 624 consecutive cycles per batch, and no batch delivers more than 624 words.
- R7: With out_ready held at 1, out_valid is low for exactly 1874 cycles between two batches.
- R8: A word is consumed only at a rising edge where out_valid and out_ready are both 1. While out_valid is 1 and out_ready is 0, out_valid and out_data hold.
- R9: A seed_load in any state drops out_valid at the next cycle and restarts the sequence from the new seed, with the R5 latency.
- R10: out_valid is 0 during seeding and during every twist pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | One-cycle strobe that starts seeding from seed_in |
| seed_in | input | 32 | Seed value sampled with seed_load |
| out_valid | output | 1 | A tempered word is present on out_data |
| out_ready | input | 1 | Consumer accepts the word this cycle |
| out_data | output | 32 | Tempered random word |

## Verification
A fault in the seeding arithmetic or in the first twist pass corrupts the very first tempered word, so it shows up at the 2497-cycle mark after the seed strobe. A fault in the wrap-around of the twist indices or in reusing freshly written words first corrupts words near the end of a batch, or the first words of the second batch, about 5000 cycles in. Errors in flow control show up as a valid run or gap length other than 624 and 1874 cycles, or as a word that changes or is lost during a stall. Every output word is therefore compared with an independent model over several batches, both under continuous and under irregular acceptance.

// File: rtl/mtg_pkg.sv
package mtg_pkg;
  localparam int WORD = 32;
  localparam logic [WORD-1:0] SEED_MULT   = 32'd1812433253;
  localparam logic [WORD-1:0] TWIST_MASK  = 32'h9908B0DF;
  localparam logic [WORD-1:0] TEMPER_B    = 32'h9D2C5680;
  localparam logic [WORD-1:0] TEMPER_C    = 32'hEFC60000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED,
    ST_TWIST,
    ST_OUT,
    ST_DRAIN
  } gen_state_t;
endpackage

// File: rtl/mtg_state_ram.sv
module mtg_state_ram #(
  parameter int DEPTH = 624,
  parameter int WIDTH = 32,
  parameter int AW    = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mtg_word_math.sv
module mtg_word_math
  import mtg_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [WORD-1:0] chain_prev,
  input  logic [AW-1:0]   chain_idx,
  output logic [WORD-1:0] seed_next,
  input  logic            upper_bit,
  input  logic [WORD-2:0] lower_bits,
  input  logic [WORD-1:0] far_word,
  output logic [WORD-1:0] twist_next
);
  logic [WORD-1:0] mix;
  logic [WORD-1:0] joined;

  always_comb begin
    mix        = chain_prev ^ (chain_prev >> 30);
    seed_next  = SEED_MULT * mix + {{(WORD-AW){1'b0}}, chain_idx};
    joined     = {upper_bit, lower_bits};
    twist_next = far_word ^ (joined >> 1) ^ (joined[0] ? TWIST_MASK : '0);
  end
endmodule

// File: rtl/mtg_temper.sv
module mtg_temper
  import mtg_pkg::*;
(
  input  logic [WORD-1:0] raw,
  output logic [WORD-1:0] tempered
);
  logic [WORD-1:0] s1, s2, s3;

  always_comb begin
    s1       = raw ^ (raw >> 11);
    s2       = s1 ^ ((s1 << 7) & TEMPER_B);
    s3       = s2 ^ ((s2 << 15) & TEMPER_C);
    tempered = s3 ^ (s3 >> 18);
  end
endmodule

// File: rtl/mt_split_gen.sv
module mt_split_gen
  import mtg_pkg::*;
#(
  parameter int N_WORDS = 624,
  parameter int SHIFT_M = 397
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            seed_load,
  input  logic [WORD-1:0] seed_in,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [WORD-1:0] out_data
);
  localparam int AW = $clog2(N_WORDS);
  localparam logic [AW-1:0] LAST_IDX = AW'(N_WORDS - 1);
  localparam logic [AW:0]   N_WIDE   = (AW+1)'(N_WORDS);
  localparam logic [AW:0]   M_WIDE   = (AW+1)'(SHIFT_M);

  gen_state_t      state;
  logic [AW-1:0]   idx;
  logic [1:0]      phase;
  logic [WORD-1:0] chain;
  logic            cur_msb;
  logic            first_msb;
  logic [WORD-1:0] nxt;
  logic [AW-1:0]   head;
  logic            pend;
  logic [AW:0]     acc_cnt;

  logic            we;
  logic [AW-1:0]   waddr, raddr;
  logic [WORD-1:0] wdata, rdata;
  logic [WORD-1:0] seed_next, twist_next, temper_out;
  logic [AW-1:0]   near_idx, far_idx, head_next;
  logic [AW:0]     far_sum;
  logic            take;

  assign near_idx  = (idx == LAST_IDX) ? '0 : idx + AW'(1);
  assign far_sum   = {1'b0, idx} + M_WIDE;
  assign far_idx   = (far_sum >= N_WIDE) ? AW'(far_sum - N_WIDE) : far_sum[AW-1:0];
  assign head_next = (head == LAST_IDX) ? '0 : head + AW'(1);
  assign take      = (state == ST_OUT) && pend && (!out_valid || out_ready);

  mtg_state_ram #(.DEPTH(N_WORDS), .WIDTH(WORD), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

  mtg_word_math #(.AW(AW)) u_math (
    .chain_prev (chain),
    .chain_idx  (idx),
    .seed_next  (seed_next),
    .upper_bit  (cur_msb),
    .lower_bits (nxt[WORD-2:0]),
    .far_word   (rdata),
    .twist_next (twist_next)
  );

  mtg_temper u_temper (
    .raw      (rdata),
    .tempered (temper_out)
  );

  // memory port steering
  always_comb begin
    we    = 1'b0;
    waddr = idx;
    wdata = seed_next;
    raddr = head;
    if (seed_load) begin
      we    = 1'b1;
      waddr = '0;
      wdata = seed_in;
    end else begin
      case (state)
        ST_SEED: we = 1'b1;
        ST_TWIST: begin
          raddr = (phase == 2'd0) ? near_idx : far_idx;
          if (phase == 2'd2) begin
            we    = 1'b1;
            wdata = twist_next;
          end
        end
        ST_OUT:  raddr = take ? head_next : head;
        default: raddr = head;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      phase     <= '0;
      head      <= '0;
      pend      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      chain     <= '0;
      cur_msb   <= 1'b0;
      first_msb <= 1'b0;
      nxt       <= '0;
    end else if (seed_load) begin
      state     <= ST_SEED;
      idx       <= AW'(1);
      chain     <= seed_in;
      first_msb <= seed_in[WORD-1];
      out_valid <= 1'b0;
      pend      <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (state)
        ST_SEED: begin
          chain <= seed_next;
          if (idx == LAST_IDX) begin
            state   <= ST_TWIST;
            idx     <= '0;
            phase   <= '0;
            cur_msb <= first_msb;
          end else begin
            idx <= idx + AW'(1);
          end
        end
        ST_TWIST: begin
          case (phase)
            2'd0: phase <= 2'd1;
            2'd1: begin
              nxt   <= rdata;
              phase <= 2'd2;
            end
            default: begin
              phase   <= 2'd0;
              cur_msb <= nxt[WORD-1];
              if (idx == '0) first_msb <= twist_next[WORD-1];
              if (idx == LAST_IDX) begin
                state <= ST_OUT;
                head  <= '0;
                pend  <= 1'b0;
              end else begin
                idx <= idx + AW'(1);
              end
            end
          endcase
        end
        ST_OUT: begin
          pend <= 1'b1;
          if (take) begin
            out_data  <= temper_out;
            out_valid <= 1'b1;
            head      <= head_next;
            if (head == LAST_IDX) begin
              state <= ST_DRAIN;
              pend  <= 1'b0;
            end
          end
        end
        ST_DRAIN: begin
          if (!out_valid || out_ready) begin
            out_valid <= 1'b0;
            state     <= ST_TWIST;
            idx       <= '0;
            phase     <= '0;
            cur_msb   <= first_msb;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // words accepted in the current batch, for checking only
  always_ff @(posedge clk) begin
    if (rst || seed_load || state == ST_TWIST) acc_cnt <= '0;
    else if (out_valid && out_ready)           acc_cnt <= acc_cnt + (AW+1)'(1);
  end

  // R1
  idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !out_valid);

  // R10
  fill_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEED || state == ST_TWIST) |-> !out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !seed_load) |=> (out_valid && $stable(out_data)));

  // R9
  seed_drop_chk: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> !out_valid);

  // R6
  batch_limit_chk: assert property (@(posedge clk) disable iff (rst)
    acc_cnt <= N_WIDE);
endmodule

// File: tb/tb_mt_split_gen.sv
module tb_mt_split_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        seed_load;
  logic [31:0] seed_in;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [31:0] GOLD [10] = '{
    32'd3499211612, 32'd581869302, 32'd3890346734, 32'd3586334585,
    32'd545404204,  32'd4161255391, 32'd3922919429, 32'd949333985,
    32'd2715962298, 32'd1323567403 };

  always #10 clk = ~clk;

  mt_split_gen dut (
    .clk       (clk),
    .rst       (rst),
    .seed_load (seed_load),
    .seed_in   (seed_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  // independent reference model
  logic [31:0] rm [624];
  int rp;

  task ref_seed(input logic [31:0] s);
    rm[0] = s;
    for (int k = 1; k < 624; k++)
      rm[k] = 32'd1812433253 * (rm[k-1] ^ (rm[k-1] >> 30)) + 32'(k);
    rp = 624;
  endtask

  task ref_twist();
    logic [31:0] y;
    for (int k = 0; k < 624; k++) begin
      y = (rm[k] & 32'h80000000) | (rm[(k+1) % 624] & 32'h7fffffff);
      rm[k] = rm[(k+397) % 624] ^ (y >> 1) ^ (y[0] ? 32'h9908b0df : 32'h0);
    end
  endtask

  task ref_next(output logic [31:0] v);
    logic [31:0] y;
    if (rp >= 624) begin
      ref_twist();
      rp = 0;
    end
    y = rm[rp];
    rp++;
    y = y ^ (y >> 11);
    y = y ^ ((y << 7) & 32'h9d2c5680);
    y = y ^ ((y << 15) & 32'hefc60000);
    y = y ^ (y >> 18);
    v = y;
  endtask

  task chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // strobe a seed at a falling edge; returns at the falling edge after it
  task load_seed(input logic [31:0] s);
    seed_in   = s;
    seed_load = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
  endtask

  // counts rising edges after the seed edge until out_valid is seen
  task wait_first(output int edges);
    edges = 0;
    while (1) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (out_valid || edges > 5000) break;
    end
  endtask

  // consume n words with ready held high, starting at a negedge showing the first
  task stream_words(input int n, input string tag);
    logic [31:0] e;
    for (int k = 0; k < n; k++) begin
      chk({tag, " valid run"}, 32'(out_valid), 32'd1);
      ref_next(e);
      chk({tag, " word"}, out_data, e);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    summary();
  end

  initial begin
    int lat, gap, consumed, cyc;
    logic [31:0] e, held;
    logic [15:0] lfsr;
    bit hold;

    rst = 1'b1; seed_load = 1'b0; seed_in = '0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    // R1 reset state
    chk("R1 valid after reset", 32'(out_valid), 32'd0);

    // R2 R4 R5 R10 seed 5489
    ref_seed(32'd5489);
    load_seed(32'd5489);
    chk("R9 valid after seed strobe", 32'(out_valid), 32'd0);
    wait_first(lat);
    chk("R5 R10 first-valid latency", 32'(lat), 32'd2497);
    for (int k = 0; k < 10; k++) begin
      ref_next(e);
      chk("R2 R4 known first words", out_data, GOLD[k]);
      chk("R6 valid in run", 32'(out_valid), 32'd1);
      @(negedge clk);
    end
    stream_words(614, "R3 R4 R6 batch1");
    // R7 gap between batches
    gap = 0;
    while (!out_valid && gap < 5000) begin
      gap++;
      @(negedge clk);
    end
    chk("R7 R10 low gap", 32'(gap), 32'd1874);
    stream_words(624, "R3 R6 batch2");
    chk("R6 valid after batch", 32'(out_valid), 32'd0);

    // R8 irregular acceptance, seed 1
    ref_seed(32'd1);
    load_seed(32'd1);
    wait_first(lat);
    chk("R5 latency seed 1", 32'(lat), 32'd2497);
    lfsr = 16'hACE1;
    hold = 0;
    consumed = 0;
    cyc = 0;
    while (consumed < 1300 && cyc < 20000) begin
      if (hold) begin
        chk("R8 valid held in stall", 32'(out_valid), 32'd1);
        chk("R8 data held in stall", out_data, held);
      end
      out_ready = lfsr[0] | lfsr[3];
      if (out_valid && out_ready) begin
        ref_next(e);
        chk("R3 R8 stalled stream word", out_data, e);
        consumed++;
        hold = 0;
      end else if (out_valid) begin
        hold = 1;
        held = out_data;
      end else begin
        hold = 0;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc++;
      @(negedge clk);
    end
    chk("R8 words consumed", 32'(consumed), 32'd1300);

    // R9 reseed in the middle of a batch
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    ref_seed(32'd42);
    load_seed(32'd42);
    chk("R9 valid drops after reseed", 32'(out_valid), 32'd0);
    wait_first(lat);
    chk("R9 R10 latency after reseed", 32'(lat), 32'd2497);
    stream_words(5, "R9 reseeded words");

    summary();
  end
endmodule